// File: doc/BRIEF.md
# Card Identity Checksum Checker

This block verifies the 8-bit checksum that follows a 64-bit card identity: four bytes of vendor code, then four bytes of serial number. The identity arrives one bit at a time on a valid/ready stream. Each accepted bit advances an 8-bit linear feedback shift register that starts from a fixed seed. The seed is 0x6A. On every step the register moves down by one place, and the XOR of its two lowest bits and the incoming bit enters at the top. After exactly 64 accepted bits, the register holds the computed checksum. The block compares it with the stored checksum byte and pulses a completion flag.

A controller starts a check with a one-cycle init pulse and then streams the identity. Bytes go in ascending address order, each byte least-significant bit first. The stream may pause at any time by dropping valid. Ready is high only while a check is in progress and fewer than 64 bits have been taken. Once the 64th bit is taken, ready falls and stays low until the next init. Valid on a cycle where ready is low transfers nothing. An init pulse always restarts from the seed, even in the middle of a check.

Top module: `ident_sum_check`

## Requirements
- R1: An init pulse loads the register with 0x6A, clears the bit count and the match flag, and raises ready on the next cycle.
- R2: Each accepted bit (valid and ready high in the same cycle) sets the new bit 7 to old bit 0 XOR old bit 1 XOR the data bit. Each new bit k, for k from 0 to 6, takes old bit k+1.
- R3: Exactly 64 bits are accepted per check. Ready falls in the cycle after the 64th acceptance.
- R4: In the cycle after the 64th acceptance, done is high for exactly one cycle and the register output shows the final value. Match is 1 when that value equals the checksum byte presented in the cycle of the 64th acceptance, and 0 otherwise.
- R5: After completion, match and the register output keep their values and done stays low until the next init.
- R6: Valid asserted while ready is low leaves the register, done and match unchanged.
- R7: An init in the middle of a check restarts it from the seed. Init takes priority over a bit offered in the same cycle, and that bit is not accepted.
- R8: After reset, ready, done and match are 0 and the register output is 0x6A.
- R9: Cycles with valid low inside a check change neither the register nor the bit count, so gaps of any length leave the result unchanged.
- R10: The identity bytes 0x43,0x11,0x43,0x04,0x00,0x01,0x00,0x02, fed in ascending byte order with each byte LSB first, give a final value of 0x1E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Start or restart a check |
| bit_valid_i | input | 1 | Identity bit offered |
| bit_ready_o | output | 1 | Block will take an offered bit |
| bit_i | input | 1 | Identity data bit |
| chk_byte_i | input | 8 | Stored checksum to compare against |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Computed checksum equals the stored one |
| lfsr_o | output | 8 | Current register value |

## Verification
A wrong tap or shift direction shows on lfsr_o one cycle after the first accepted bit that exposes it. It then makes the final value and match disagree with a bit-serial model. A miscounting bit counter shows up as done arriving one acceptance early or late, or as ready staying high after the 64th bit. It is caught at the completion cycle of every check. Ignored strobes and stalls that leak into the state appear at once as a change on lfsr_o while ready or valid is low.

// File: rtl/ident_chk_pkg.sv
package ident_chk_pkg;
  localparam int unsigned LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h6A;
  localparam int unsigned ID_BITS = 64;

  // One step of the identity checksum register
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur,
                                                   input logic din);
    lfsr_step = {cur[0] ^ cur[1] ^ din, cur[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/ident_shift_ctrl.sv
module ident_shift_ctrl #(
  parameter int unsigned N_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic valid,
  output logic ready,
  output logic accept,
  output logic last_accept
);
  localparam int unsigned CNT_W = $clog2(N_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BITS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready       = active_q;
  assign accept      = valid && active_q && !init;
  assign last_accept = accept && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (init) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (accept) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(N_BITS)); // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    last_accept |=> !ready); // R3
  AST_INIT_READY: assert property (@(posedge clk) disable iff (rst)
    init |=> (ready && cnt_q == '0)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init && !valid) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/ident_lfsr.sv
module ident_lfsr
  import ident_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              accept,
  input  logic              din,
  output logic [LFSR_W-1:0] state,
  output logic [LFSR_W-1:0] state_nxt
);
  logic [LFSR_W-1:0] reg_q;

  assign state     = reg_q;
  assign state_nxt = lfsr_step(reg_q, din);

  always_ff @(posedge clk) begin
    if (rst || init) reg_q <= LFSR_SEED;
    else if (accept) reg_q <= state_nxt;
  end

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    init |=> (reg_q == LFSR_SEED)); // R1
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (accept && !init) |=> (reg_q[LFSR_W-2:0] == $past(reg_q[LFSR_W-1:1]))); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!accept && !init) |=> $stable(reg_q)); // R6
endmodule

// File: rtl/ident_cmp.sv
module ident_cmp
  import ident_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              finish,
  input  logic [LFSR_W-1:0] calc,
  input  logic [LFSR_W-1:0] stored,
  output logic              done,
  output logic              match
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      match <= 1'b0;
    end else begin
      done <= finish && !init;
      if (init)        match <= 1'b0;
      else if (finish) match <= (calc == stored);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init && !finish) |=> $stable(match)); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    init |=> (!match && !done)); // R1
endmodule

// File: rtl/ident_sum_check.sv
module ident_sum_check
  import ident_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              bit_valid_i,
  output logic              bit_ready_o,
  input  logic              bit_i,
  input  logic [LFSR_W-1:0] chk_byte_i,
  output logic              done_o,
  output logic              match_o,
  output logic [LFSR_W-1:0] lfsr_o
);
  logic              acc;
  logic              fin;
  logic [LFSR_W-1:0] nxt;

  ident_shift_ctrl #(.N_BITS(ID_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .init(init_i), .valid(bit_valid_i),
    .ready(bit_ready_o), .accept(acc), .last_accept(fin)
  );

  ident_lfsr u_lfsr (
    .clk(clk), .rst(rst), .init(init_i), .accept(acc), .din(bit_i),
    .state(lfsr_o), .state_nxt(nxt)
  );

  ident_cmp u_cmp (
    .clk(clk), .rst(rst), .init(init_i), .finish(fin), .calc(nxt),
    .stored(chk_byte_i), .done(done_o), .match(match_o)
  );

  AST_NO_TAKE_WHEN_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bit_ready_o); // R3
endmodule

// File: tb/ident_sum_check_bench.sv
module ident_sum_check_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] chk_byte_i = 8'h00;
  logic       bit_ready_o, done_o, match_o;
  logic [7:0] lfsr_o;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ident_sum_check u_ident_sum_check (
    .clk(clk), .rst(rst), .init_i(init_i), .bit_valid_i(bit_valid_i),
    .bit_ready_o(bit_ready_o), .bit_i(bit_i), .chk_byte_i(chk_byte_i),
    .done_o(done_o), .match_o(match_o), .lfsr_o(lfsr_o)
  );

  function automatic logic [7:0] model(input logic [63:0] id, input int nbits);
    logic [7:0] r = 8'h6A;
    for (int i = 0; i < nbits; i++) r = {r[0] ^ r[1] ^ id[i], r[7:1]};
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start();
    @(negedge clk); init_i = 1'b1; bit_valid_i = 1'b0;
    @(negedge clk); init_i = 1'b0;
    check(lfsr_o == 8'h6A, "R1 seed", lfsr_o, 8'h6A);
    check(bit_ready_o == 1'b1, "R1 ready", bit_ready_o, 1);
    check(match_o == 1'b0, "R1 match cleared", match_o, 0);
  endtask

  // feed bits [0..n-1]; optional random gaps
  task automatic feed(input logic [63:0] id, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        logic [7:0] hold;
        bit_valid_i = 1'b0; bit_i = ~id[i];
        hold = lfsr_o;
        @(negedge clk);
        check(lfsr_o == hold, "R9 stall", lfsr_o, hold);
      end
      bit_valid_i = 1'b1; bit_i = id[i];
      @(negedge clk);
      if (i == 0) check(lfsr_o == model(id, 1), "R2 first step", lfsr_o, model(id, 1));
    end
    bit_valid_i = 1'b0;
  endtask

  task automatic full_run(input logic [63:0] id, input logic [7:0] chk, input bit gaps);
    logic [7:0] exp = model(id, 64);
    chk_byte_i = chk;
    start();
    feed(id, 64, gaps);
    check(done_o == 1'b1, "R4 done", done_o, 1);
    check(lfsr_o == exp, "R4 final", lfsr_o, exp);
    check(match_o == (exp == chk), "R4 match", match_o, (exp == chk));
    check(bit_ready_o == 1'b0, "R3 ready low", bit_ready_o, 0);
    // extra strobes after completion
    bit_valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R5 done single", done_o, 0);
    @(negedge clk);
    bit_valid_i = 1'b0;
    check(lfsr_o == exp, "R6 ignored strobe", lfsr_o, exp);
    check(match_o == (exp == chk), "R5 match held", match_o, (exp == chk));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ex;
    void'($urandom(32'd1234));
    ex = {8'h02, 8'h00, 8'h01, 8'h00, 8'h04, 8'h43, 8'h11, 8'h43};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bit_ready_o == 1'b0, "R8 ready", bit_ready_o, 0);
    check(done_o == 1'b0, "R8 done", done_o, 0);
    check(match_o == 1'b0, "R8 match", match_o, 0);
    check(lfsr_o == 8'h6A, "R8 lfsr", lfsr_o, 8'h6A);
    // strobe before any init is ignored
    bit_valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    bit_valid_i = 1'b0;
    check(lfsr_o == 8'h6A, "R6 idle strobe", lfsr_o, 8'h6A);

    // worked example
    check(model(ex, 64) == 8'h1E, "R10 model", model(ex, 64), 8'h1E);
    full_run(ex, 8'h1E, 1'b0);
    check(lfsr_o == 8'h1E, "R10 result", lfsr_o, 8'h1E);
    full_run(ex, 8'h1F, 1'b1);

    // restart mid-sequence, init together with an offered bit
    chk_byte_i = 8'h1E;
    start();
    feed(~ex, 20, 1'b0);
    @(negedge clk);
    init_i = 1'b1; bit_valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0; bit_valid_i = 1'b0;
    check(lfsr_o == 8'h6A, "R7 restart seed", lfsr_o, 8'h6A);
    feed(ex, 64, 1'b0);
    check(done_o && match_o && lfsr_o == 8'h1E, "R7 restart result", lfsr_o, 8'h1E);

    // random identities
    for (int k = 0; k < 12; k++) begin
      logic [63:0] id;
      logic [7:0] c;
      id = {$urandom, $urandom};
      c = (k % 2 == 0) ? model(id, 64) : 8'($urandom);
      full_run(id, c, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule